// File: doc/BRIEF.md
# Port and Scratch Pad Access Unit

This unit carries out the memory and I/O class of instructions of a small 8-bit controller: reads and writes on an external 8-bit port bus, and loads and stores to a private scratch store of 32 bytes. A build option adds a 256-byte scratch memory outside the block. That memory shares the port address bus and the output data bus, and it has its own read and write strobes. Every instruction in the class carries the major opcode `11110` in bits 17:13. Bits 2:0 choose the operation. Bit 2 selects the scratch store. Bit 1 selects indirect addressing through Rb. Bit 0 marks a read.

The surrounding core pulses `exec_en` for one cycle and presents the instruction, the Rd value and the Rb value in that same cycle. The unit latches these operands. It then finishes the instruction in the cycle that follows, and all strobes fire only in that second cycle. Port reads and scratch loads return a byte on `load_data`, and `load_valid` marks it for the cycle after the second cycle. Writing that byte back into the register file is the core's job.

Top module: `portmem_unit`

## Requirements
- R1: Only an instruction with bits 17:13 equal to `11110` is acted on. For that class, bits 2:0 encode 000 port write direct, 001 port read direct, 010 port write indirect, 011 port read indirect, 100 scratch store direct, 101 scratch load direct, 110 scratch store indirect, 111 scratch load indirect. Any other major opcode raises no strobe and no `load_valid`, stores nothing, and leaves `port_addr` at 0.
- R2: After reset every strobe, `load_valid`, `load_data`, `port_addr` and `port_dout` are 0, and every byte of the internal scratch store reads back as 0.
- R3: In the first cycle of an instruction all four strobes are low. At most one strobe is high in any cycle.
- R4: A direct form puts bits 7:3 on `port_addr`, zero-extended. An indirect form puts the full Rb value there. The address is the same in both cycles, and it stays the same even when Rb changes after the first cycle.
- R5: A port read raises `port_rd` in the second cycle and samples `port_din` at the end of that cycle. The byte then appears on `load_data`, with `load_valid` high for exactly the next cycle.
- R6: A port write raises `port_wr` in the second cycle and drives `port_dout` with the Rd value captured in the first cycle. At all other times `port_dout` is 0, except during an external scratch write.
- R7: Direct scratch store and direct scratch load reach the internal 32-byte store at index bits 7:3. A load returns the stored byte with the timing of R5.
- R8: With `EXT_SPAD`=1, an indirect store raises `xmem_wr`, with Rb on `port_addr` and Rd on `port_dout`. An indirect load raises `xmem_rd` and returns `xmem_din`. Neither of them touches the internal store.
- R9: With `EXT_SPAD`=0, the indirect scratch forms reach the internal store at index Rb[4:0], and `xmem_rd` and `xmem_wr` stay low.
- R10: An `exec_en` pulse that arrives during the second cycle of an instruction is ignored.
- R11: `load_valid` rises only after one of the four read operations (bit 0 = 1). A write or a store never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | First cycle of an instruction |
| instr | input | 18 | Instruction word, sampled with `exec_en` |
| rd_val | input | 8 | Rd register value, sampled with `exec_en` |
| rb_val | input | 8 | Rb register value, sampled with `exec_en` |
| port_din | input | 8 | Port read data |
| xmem_din | input | 8 | External scratch read data |
| port_addr | output | 8 | Shared port / external scratch address |
| port_dout | output | 8 | Shared output data |
| port_rd | output | 1 | Port read strobe |
| port_wr | output | 1 | Port write strobe |
| xmem_rd | output | 1 | External scratch read strobe |
| xmem_wr | output | 1 | External scratch write strobe |
| load_valid | output | 1 | `load_data` holds a fresh byte for Rd |
| load_data | output | 8 | Loaded byte |

## Verification
The bench builds two copies side by side from one stimulus stream: `u_dut` with `EXT_SPAD`=1 and `u_dut_noext` with `EXT_SPAD`=0, both with 32 scratch words. The first copy reaches the external strobes. It also shows that indirect stores leave internal bytes alone. The second copy shows the indirect forms folding onto the internal store through the low five bits of Rb, including an address with its upper bits set.

// File: rtl/pau_pkg.sv
package pau_pkg;
  localparam int unsigned DW    = 8;   // data and bus width
  localparam int unsigned IW    = 18;  // instruction width
  localparam int unsigned DIR_W = 5;   // direct address field width
  localparam logic [4:0]  MAJOR_MEMIO = 5'b11110;

  // operation bits: [2] scratch, [1] indirect, [0] read
  typedef struct packed {
    logic          valid;
    logic          is_spad;
    logic          indirect;
    logic          is_read;
    logic [DW-1:0] addr;
    logic [DW-1:0] wdata;
  } mcmd_t;

  function automatic logic [DW-1:0] bus_addr(input logic indirect,
                                             input logic [DIR_W-1:0] imm,
                                             input logic [DW-1:0] rb);
    return indirect ? rb : {{(DW-DIR_W){1'b0}}, imm};
  endfunction

  function automatic logic [DW-1:0] pick_load(input logic is_spad,
                                              input logic ext_route,
                                              input logic [DW-1:0] pdin,
                                              input logic [DW-1:0] xdin,
                                              input logic [DW-1:0] idin);
    if (!is_spad)  return pdin;
    if (ext_route) return xdin;
    return idin;
  endfunction
endpackage

// File: rtl/pau_decode.sv
module pau_decode
  import pau_pkg::*;
(
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] rd_val,
  input  logic [DW-1:0] rb_val,
  output mcmd_t         cmd
);
  logic [2:0] op;
  assign op = instr[2:0];

  always_comb begin
    cmd          = '0;
    cmd.valid    = (instr[IW-1:IW-5] == MAJOR_MEMIO);
    cmd.is_spad  = op[2];
    cmd.indirect = op[1];
    cmd.is_read  = op[0];
    cmd.addr     = bus_addr(op[1], instr[DIR_W+2:3], rb_val);
    cmd.wdata    = rd_val;
  end
endmodule

// File: rtl/pau_seq.sv
module pau_seq
  import pau_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  exec_en,
  input  mcmd_t cmd_in,
  output logic  start_evt,
  output logic  in_second,
  output mcmd_t cmd_q
);
  assign start_evt = exec_en & ~in_second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_second <= 1'b0;
      cmd_q     <= '0;
    end else begin
      in_second <= start_evt;
      if (start_evt) cmd_q <= cmd_in;
    end
  end
endmodule

// File: rtl/pau_spad.sv
module pau_spad
  import pau_pkg::*;
#(
  parameter int unsigned WORDS = 32,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mem[g] <= '0;
      else if (we && (idx == AW'(g)))           mem[g] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/portmem_unit.sv
module portmem_unit
  import pau_pkg::*;
#(
  parameter int unsigned EXT_SPAD   = 1,
  parameter int unsigned SPAD_WORDS = 32,
  localparam int unsigned SAW       = $clog2(SPAD_WORDS),
  localparam logic HAS_EXT          = (EXT_SPAD != 0)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic [17:0]   instr,
  input  logic [7:0]    rd_val,
  input  logic [7:0]    rb_val,
  input  logic [7:0]    port_din,
  input  logic [7:0]    xmem_din,
  output logic [7:0]    port_addr,
  output logic [7:0]    port_dout,
  output logic          port_rd,
  output logic          port_wr,
  output logic          xmem_rd,
  output logic          xmem_wr,
  output logic          load_valid,
  output logic [7:0]    load_data
);
  mcmd_t         dec_cmd, cmd_q;
  logic          start_evt, in_second;
  logic          act, ext_route, int_we, rd_evt, start_port_op;
  logic [DW-1:0] spad_rdata;

  pau_decode u_dec (
    .instr(instr), .rd_val(rd_val), .rb_val(rb_val), .cmd(dec_cmd)
  );

  pau_seq u_seq (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .cmd_in(dec_cmd),
    .start_evt(start_evt), .in_second(in_second), .cmd_q(cmd_q)
  );

  // named events for the checker
  assign start_port_op = start_evt & dec_cmd.valid & ~dec_cmd.is_spad;
  assign act           = in_second & cmd_q.valid;
  assign ext_route     = HAS_EXT & cmd_q.is_spad & cmd_q.indirect;
  assign rd_evt        = act & cmd_q.is_read;
  assign int_we        = act & cmd_q.is_spad & ~ext_route & ~cmd_q.is_read;

  assign port_rd = act & ~cmd_q.is_spad &  cmd_q.is_read;
  assign port_wr = act & ~cmd_q.is_spad & ~cmd_q.is_read;
  assign xmem_rd = act & ext_route      &  cmd_q.is_read;
  assign xmem_wr = act & ext_route      & ~cmd_q.is_read;

  always_comb begin
    if (in_second)                        port_addr = cmd_q.valid ? cmd_q.addr : '0;
    else if (start_evt && dec_cmd.valid)  port_addr = dec_cmd.addr;
    else                                  port_addr = '0;
  end

  assign port_dout = (port_wr | xmem_wr) ? cmd_q.wdata : '0;

  pau_spad #(.WORDS(SPAD_WORDS)) u_spad (
    .clk(clk), .rst_n(rst_n), .we(int_we),
    .idx(cmd_q.addr[SAW-1:0]), .wdata(cmd_q.wdata), .rdata(spad_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_valid <= 1'b0;
      load_data  <= '0;
    end else begin
      load_valid <= rd_evt;
      if (rd_evt)
        load_data <= pick_load(cmd_q.is_spad, ext_route, port_din, xmem_din, spad_rdata);
    end
  end
endmodule

// File: rtl/pau_check.sv
module pau_check #(
  parameter int unsigned EXT_SPAD = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       port_rd,
  input logic       port_wr,
  input logic       xmem_rd,
  input logic       xmem_wr,
  input logic [7:0] port_addr,
  input logic       load_valid,
  input logic       in_second,
  input logic       start_port_op
);
  logic any_strb;
  assign any_strb = port_rd | port_wr | xmem_rd | xmem_wr;

  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({port_rd, port_wr, xmem_rd, xmem_wr}));

  assert_strobe_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_strb |-> in_second);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_port_op |=> $stable(port_addr));

  assert_read_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd | xmem_rd) |=> load_valid);

  assert_second_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_second |=> !in_second);

  assert_load_after_second_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $past(in_second));

  if (EXT_SPAD == 0) begin : g_noext
    assert_xmem_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(xmem_rd | xmem_wr));
  end
endmodule

bind portmem_unit pau_check #(.EXT_SPAD(EXT_SPAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_rd(port_rd), .port_wr(port_wr),
  .xmem_rd(xmem_rd), .xmem_wr(xmem_wr), .port_addr(port_addr),
  .load_valid(load_valid), .in_second(in_second), .start_port_op(start_port_op)
);

// File: tb/portmem_unit_tb.sv
module portmem_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exec_en = 1'b0;
  logic [17:0] instr = '0;
  logic [7:0] rd_val = '0, rb_val = '0, port_din = '0, xmem_din = '0;

  logic [7:0] a_addr, a_dout, a_ld, b_addr, b_dout, b_ld;
  logic a_prd, a_pwr, a_xrd, a_xwr, a_lv, b_prd, b_pwr, b_xrd, b_xwr, b_lv;

  always #2.5 clk = ~clk;  // 200 MHz

  portmem_unit #(.EXT_SPAD(1), .SPAD_WORDS(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr), .rd_val(rd_val),
    .rb_val(rb_val), .port_din(port_din), .xmem_din(xmem_din), .port_addr(a_addr),
    .port_dout(a_dout), .port_rd(a_prd), .port_wr(a_pwr), .xmem_rd(a_xrd),
    .xmem_wr(a_xwr), .load_valid(a_lv), .load_data(a_ld));

  portmem_unit #(.EXT_SPAD(0), .SPAD_WORDS(32)) u_dut_noext (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr), .rd_val(rd_val),
    .rb_val(rb_val), .port_din(port_din), .xmem_din(xmem_din), .port_addr(b_addr),
    .port_dout(b_dout), .port_rd(b_prd), .port_wr(b_pwr), .xmem_rd(b_xrd),
    .xmem_wr(b_xwr), .load_valid(b_lv), .load_data(b_ld));

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] mk(input logic [4:0] major, input logic [2:0] op,
                                     input logic [4:0] imm);
    return {major, 5'd3, imm, op};
  endfunction

  // snapshots: c = ext copy, n = no-ext copy; 1/2 = instruction cycles, 3 = after
  logic [3:0] c1_s, c2_s, n2_s;
  logic [7:0] c1_a, c2_a, c2_d, c3_ld, n3_ld;
  logic       c3_lv, n3_lv;

  task automatic run(input logic [17:0] ins, input logic [7:0] rd, input logic [7:0] rb,
                     input logic [7:0] din, input bit hold);
    @(posedge clk); #1;
    exec_en = 1'b1; instr = ins; rd_val = rd; rb_val = rb;
    @(negedge clk);
    c1_s = {a_prd, a_pwr, a_xrd, a_xwr}; c1_a = a_addr;
    @(posedge clk); #1;
    exec_en = hold; instr = mk(5'b11110, 3'b001, 5'd2);
    rd_val = ~rd; rb_val = ~rb; port_din = din; xmem_din = din ^ 8'hFF;
    @(negedge clk);
    c2_s = {a_prd, a_pwr, a_xrd, a_xwr}; c2_a = a_addr; c2_d = a_dout;
    n2_s = {b_prd, b_pwr, b_xrd, b_xwr};
    @(posedge clk); #1;
    exec_en = 1'b0; port_din = '0; xmem_din = '0;
    @(negedge clk);
    c3_lv = a_lv; c3_ld = a_ld; n3_lv = b_lv; n3_ld = b_ld;
  endtask

  typedef struct packed {
    logic [4:0] major; logic [2:0] op; logic [4:0] imm;
    logic [7:0] rd; logic [7:0] rb; logic [7:0] din;
    logic [7:0] e_addr; logic [3:0] e_strb; logic [7:0] e_dout;
    logic e_lv; logic [7:0] e_ld;
  } vec_t;

  // strobe order {port_rd, port_wr, xmem_rd, xmem_wr}; ext copy
  localparam vec_t VECS [12] = '{
    '{5'h1E, 3'b000, 5'd7,  8'hA5, 8'h00, 8'h00, 8'h07, 4'b0100, 8'hA5, 1'b0, 8'h00},
    '{5'h1E, 3'b001, 5'd31, 8'h00, 8'h00, 8'h3C, 8'h1F, 4'b1000, 8'h00, 1'b1, 8'h3C},
    '{5'h1E, 3'b010, 5'd0,  8'h5A, 8'hC8, 8'h00, 8'hC8, 4'b0100, 8'h5A, 1'b0, 8'h00},
    '{5'h1E, 3'b011, 5'd0,  8'h00, 8'hFF, 8'h81, 8'hFF, 4'b1000, 8'h00, 1'b1, 8'h81},
    '{5'h1E, 3'b100, 5'd4,  8'h77, 8'h00, 8'h00, 8'h04, 4'b0000, 8'h00, 1'b0, 8'h00},
    '{5'h1E, 3'b101, 5'd4,  8'h00, 8'h00, 8'h00, 8'h04, 4'b0000, 8'h00, 1'b1, 8'h77},
    '{5'h1E, 3'b110, 5'd0,  8'hE1, 8'h90, 8'h00, 8'h90, 4'b0001, 8'hE1, 1'b0, 8'h00},
    '{5'h1E, 3'b111, 5'd0,  8'h00, 8'h90, 8'h11, 8'h90, 4'b0010, 8'h00, 1'b1, 8'hEE},
    '{5'h1E, 3'b101, 5'd16, 8'h00, 8'h90, 8'h00, 8'h10, 4'b0000, 8'h00, 1'b1, 8'h00},
    '{5'h09, 3'b001, 5'd5,  8'h12, 8'h34, 8'h56, 8'h00, 4'b0000, 8'h00, 1'b0, 8'h00},
    '{5'h1E, 3'b100, 5'd31, 8'h3F, 8'h00, 8'h00, 8'h1F, 4'b0000, 8'h00, 1'b0, 8'h00},
    '{5'h1E, 3'b101, 5'd31, 8'h00, 8'h00, 8'h00, 8'h1F, 4'b0000, 8'h00, 1'b1, 8'h3F}
  };

  function automatic string load_req(input logic [4:0] major, input logic [2:0] op);
    if (major != 5'h1E)  return "R1";
    if (op == 3'b101)    return "R7";
    if (op == 3'b111)    return "R8";
    if (op[0])           return "R5";
    return "R11";
  endfunction

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    chk({a_prd, a_pwr, a_xrd, a_xwr, a_lv} == 5'b0, "R2 strobes", int'({a_prd, a_pwr, a_xrd, a_xwr, a_lv}), 0);
    chk(a_addr == 8'h00 && a_dout == 8'h00 && a_ld == 8'h00, "R2 buses", int'({a_addr, a_dout, a_ld}), 0);

    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      run(mk(v.major, v.op, v.imm), v.rd, v.rb, v.din, 1'b0);
      chk(c1_s == 4'b0, "R3 first cycle", int'(c1_s), 0);
      chk(c1_a == v.e_addr, "R4 addr cycle1", int'(c1_a), int'(v.e_addr));
      chk(c2_a == v.e_addr, "R4 addr cycle2", int'(c2_a), int'(v.e_addr));
      chk(c2_s == v.e_strb, "R1 strobes", int'(c2_s), int'(v.e_strb));
      chk(c2_d == v.e_dout, "R6 dout", int'(c2_d), int'(v.e_dout));
      chk(c3_lv == v.e_lv, {load_req(v.major, v.op), " valid"}, int'(c3_lv), int'(v.e_lv));
      if (v.e_lv) chk(c3_ld == v.e_ld, {load_req(v.major, v.op), " data"}, int'(c3_ld), int'(v.e_ld));
    end

    // R9 / R8: indirect store with Rb upper bits set
    run(mk(5'h1E, 3'b110, 5'd0), 8'h9C, 8'hE5, 8'h00, 1'b0);
    chk(n2_s == 4'b0, "R9 no xmem strobe", int'(n2_s), 0);
    chk(c2_s == 4'b0001, "R8 xmem_wr", int'(c2_s), 1);
    run(mk(5'h1E, 3'b101, 5'd5), 8'h00, 8'h00, 8'h00, 1'b0);
    chk(n3_lv && n3_ld == 8'h9C, "R9 folded store", int'(n3_ld), 'h9C);
    chk(c3_lv && c3_ld == 8'h00, "R8 internal untouched", int'(c3_ld), 0);
    run(mk(5'h1E, 3'b111, 5'd0), 8'h00, 8'h25, 8'h40, 1'b0);
    chk(n2_s == 4'b0, "R9 indirect load quiet", int'(n2_s), 0);
    chk(n3_lv && n3_ld == 8'h9C, "R9 folded load", int'(n3_ld), 'h9C);
    chk(c3_ld == 8'hBF, "R8 xmem load", int'(c3_ld), 'hBF);

    // R10: exec_en held into the second cycle with a read instruction
    run(mk(5'h1E, 3'b000, 5'd9), 8'h66, 8'h00, 8'h00, 1'b1);
    chk(c2_s == 4'b0100, "R10 write completes", int'(c2_s), 4);
    chk(c3_lv == 1'b0, "R10 no load", int'(c3_lv), 0);
    @(negedge clk);
    chk({a_prd, a_pwr, a_xrd, a_xwr} == 4'b0, "R10 no second op", int'({a_prd, a_pwr, a_xrd, a_xwr}), 0);
    chk(a_lv == 1'b0, "R11 one-cycle valid", int'(a_lv), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule